// File: doc/BRIEF.md
# Serial Control Register Bank for a Multi-Channel Audio Processor

This block is a write-only two-wire serial slave. It receives control bytes for a three-channel audio processor and keeps them in six byte-wide registers. A fast system clock oversamples the clock and data lines. The block finds start and stop conditions, compares the first byte of a frame with its write address, and pulls the data line low during the ninth clock of every byte it accepts. It drives the data line as an open-drain output, through an output-enable.

The byte after the address is a sub-address. Its low nibble selects the first target register. Its top bit selects the burst mode:
- **Top bit 0:** each further data byte goes to the next register.
- **Top bit 1:** every data byte of the burst rewrites the same register.

The block decodes the stored registers into fields: channel volumes, tone codes, a surround level and switch bits. It drives these fields straight to the analog side. The system clock must run at least 20 times faster than the serial clock.

Top module: `i2c_ctl_bank`

## Requirements
- R1: A frame begins only at a start condition (SDA falls while SCL is high) and ends at a stop condition (SDA rises while SCL is high). Clocked bytes that arrive after a stop and before the next start are neither acknowledged nor stored.
- R2: An address byte of 0x80 (7-bit address 0x40, write) is acknowledged by holding SDA low during the ninth clock. Any other address byte, including the read form 0x81, gets no acknowledge. Every later byte up to the next start then gets no acknowledge and is not stored.
- R3: After a matching address, the sub-address byte and every data byte are acknowledged, whether or not the target register exists.
- R4: A sub-address whose upper nibble is 0 sets the pointer to its low nibble. After each data byte the pointer advances by one. The pointer stays at register 5 once it reaches it.
- R5: A sub-address whose upper nibble is 8 sets the pointer to its low nibble. Every data byte of the burst overwrites that one register.
- R6: A sub-address with bits 6..4 not all zero, or with a low nibble above 5, is unmapped. Data bytes aimed at it are acknowledged, but no register changes.
- R7: Volume fields are 6 bits each, with 0x00 as minimum and 0x3F as maximum. Left volume is bits 5..0 of register 0. Right volume is bits 5..0 of register 1. Center volume is bits 5..0 of register 2.
- R8: Tone and surround fields are 4 bits each. Treble is bits 3..0 of register 3. Surround level is bits 3..0 of register 4. Bass is bits 3..0 of register 5.
- R9: Each switch bit means on at 1. The switch bits are: AGC enable (register 0 bit 7), main mute (register 1 bit 7), center mute (register 2 bit 7), surround enable (register 2 bit 6), bass mix (register 3 bit 7), center source (register 4 bit 7, where 1 selects the external input and 0 selects the internal L+R sum), loop enable (register 5 bit 7) and extension DAC level (register 5 bit 6, where 1 drives high).
- R10: Synchronous reset loads register 1 and register 2 with 0x80 and all other registers with 0x00. After reset, both mutes are on and all volumes are at minimum.
- R11: The block switches its SDA drive on and off only while SCL is low. It releases SDA after the falling edge that ends the ninth clock, and whenever a stop condition occurs.
- R12: A start condition in the middle of a frame (repeated start) restarts address reception. A second burst in the same frame is then stored according to its own sub-address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pulls SDA low when 1 (open-drain acknowledge) |
| vol_left | output | 6 | Left channel volume code |
| vol_right | output | 6 | Right channel volume code |
| vol_ctr | output | 6 | Center channel volume code |
| treble | output | 4 | Shared treble code |
| bass | output | 4 | Shared bass code |
| surround_lvl | output | 4 | Surround effect level |
| agc_en | output | 1 | Automatic gain control on |
| mute | output | 1 | Main mute on |
| ctr_mute | output | 1 | Center mute on |
| surround_en | output | 1 | Surround on |
| bass_mix_en | output | 1 | Bass mixing on |
| ctr_src_ext | output | 1 | Center from external input (1) or from L+R (0) |
| loop_en | output | 1 | Surround loop on |
| ext_dac | output | 1 | Extension DAC output level |

## Verification
The bench looks for these faults:

| Case | Stimulus | A faulty design would |
|---|---|---|
| Pointer end | An auto-increment burst that runs past register 5 | Wrap the pointer, or run it into unmapped space, and corrupt register 0 |
| Renewal burst | A renewal burst | Spread its bytes over neighbouring registers |
| Unmapped sub-address | An unmapped sub-address, including one with upper nibble 9 | Withhold the acknowledge, or alias the write onto a real register |
| Bad address | A foreign address and the read address | Acknowledge them, or keep listening after them |
| Stray bytes | Bytes clocked after a stop with no new start | Store them |
| Repeated start | A repeated start between two bursts | Keep the old phase, and take the new address byte as data |

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;

    localparam int BYTE_W    = 8;
    localparam int REG_COUNT = 6;
    localparam int BANK_W    = REG_COUNT * BYTE_W;
    localparam int VOL_W     = 6;
    localparam int TONE_W    = 4;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [BANK_W-1:0] bank_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK_WAIT,
        ST_ACK_DRIVE,
        ST_IGNORE
    } rx_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_SUB,
        PH_DATA
    } rx_phase_e;

    typedef struct packed {
        logic [VOL_W-1:0]  vol_left;
        logic [VOL_W-1:0]  vol_right;
        logic [VOL_W-1:0]  vol_ctr;
        logic [TONE_W-1:0] treble;
        logic [TONE_W-1:0] bass;
        logic [TONE_W-1:0] surround_lvl;
        logic              agc_en;
        logic              mute;
        logic              ctr_mute;
        logic              surround_en;
        logic              bass_mix_en;
        logic              ctr_src_ext;
        logic              loop_en;
        logic              ext_dac;
    } ctl_fields_t;

    // Reset value per register: both mutes on, everything else zero.
    function automatic byte_t reg_default(input int idx);
        return (idx == 1 || idx == 2) ? 8'h80 : 8'h00;
    endfunction

    function automatic byte_t bank_byte(input bank_t b, input int idx);
        return b[idx*BYTE_W +: BYTE_W];
    endfunction

    function automatic ctl_fields_t decode_bank(input bank_t b);
        ctl_fields_t f;
        byte_t r0, r1, r2, r3, r4, r5;
        r0 = bank_byte(b, 0);
        r1 = bank_byte(b, 1);
        r2 = bank_byte(b, 2);
        r3 = bank_byte(b, 3);
        r4 = bank_byte(b, 4);
        r5 = bank_byte(b, 5);
        f.vol_left     = r0[5:0];
        f.agc_en       = r0[7];
        f.vol_right    = r1[5:0];
        f.mute         = r1[7];
        f.vol_ctr      = r2[5:0];
        f.surround_en  = r2[6];
        f.ctr_mute     = r2[7];
        f.treble       = r3[3:0];
        f.bass_mix_en  = r3[7];
        f.surround_lvl = r4[3:0];
        f.ctr_src_ext  = r4[7];
        f.bass         = r5[3:0];
        f.ext_dac      = r5[6];
        f.loop_en      = r5[7];
        return f;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_s,
    output logic line_rise,
    output logic line_fall
);

    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], line_in};
            prev  <= chain[STAGES-1];
        end
    end

    assign line_s    = chain[STAGES-1];
    assign line_rise = line_s & ~prev;
    assign line_fall = ~line_s & prev;

endmodule

// File: rtl/i2c_rx_fsm.sv
module i2c_rx_fsm
    import i2c_ctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h40
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  scl_s,
    input  logic  scl_rise,
    input  logic  scl_fall,
    input  logic  sda_s,
    input  logic  sda_rise,
    input  logic  sda_fall,
    output logic  start_det,
    output logic  stop_det,
    output logic  sda_oe,
    output logic  ignoring,
    output logic  byte_stb,
    output logic  byte_is_sub,
    output byte_t byte_data
);

    localparam byte_t ADDR_BYTE = {DEV_ADDR, 1'b0};

    rx_state_e  state;
    rx_phase_e  phase;
    logic [2:0] bit_cnt;
    logic [6:0] shreg;
    byte_t      next_byte;
    logic       byte_done;

    assign start_det = scl_s & sda_fall;
    assign stop_det  = scl_s & sda_rise;
    assign next_byte = {shreg, sda_s};
    assign byte_done = (state == ST_RECV) && scl_rise && (bit_cnt == 3'd7)
                       && !start_det && !stop_det;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            phase   <= PH_ADDR;
            bit_cnt <= '0;
            shreg   <= '0;
            sda_oe  <= 1'b0;
        end else if (start_det) begin
            state   <= ST_RECV;
            phase   <= PH_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else begin
            case (state)
                ST_RECV: begin
                    if (scl_rise) begin
                        shreg <= next_byte[6:0];
                        if (bit_cnt == 3'd7) begin
                            bit_cnt <= '0;
                            if (phase == PH_ADDR && next_byte != ADDR_BYTE)
                                state <= ST_IGNORE;
                            else
                                state <= ST_ACK_WAIT;
                        end else begin
                            bit_cnt <= bit_cnt + 3'd1;
                        end
                    end
                end
                ST_ACK_WAIT: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b1;
                        state  <= ST_ACK_DRIVE;
                    end
                end
                ST_ACK_DRIVE: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RECV;
                        phase  <= (phase == PH_ADDR) ? PH_SUB : PH_DATA;
                    end
                end
                default: ;
            endcase
        end
    end

    assign ignoring    = (state == ST_IGNORE);
    assign byte_stb    = byte_done && (phase != PH_ADDR);
    assign byte_is_sub = (phase == PH_SUB);
    assign byte_data   = next_byte;

endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
    import i2c_ctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  byte_stb,
    input  logic  byte_is_sub,
    input  byte_t byte_data,
    output logic  wr_en,
    output bank_t bank
);

    localparam logic [3:0] LAST_IDX = 4'(REG_COUNT - 1);

    logic [3:0] ptr;
    logic       ptr_ok;
    logic       renew;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr    <= '0;
            ptr_ok <= 1'b0;
            renew  <= 1'b0;
        end else if (byte_stb && byte_is_sub) begin
            ptr    <= byte_data[3:0];
            ptr_ok <= (byte_data[6:4] == 3'b000) && (byte_data[3:0] <= LAST_IDX);
            renew  <= byte_data[7];
        end else if (byte_stb && !renew && ptr_ok && ptr < LAST_IDX) begin
            ptr <= ptr + 4'd1;
        end
    end

    assign wr_en = byte_stb && !byte_is_sub && ptr_ok;

    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
        byte_t q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= reg_default(i);
            else if (wr_en && ptr == 4'(i))
                q <= byte_data;
        end
        assign bank[i*BYTE_W +: BYTE_W] = q;
    end

endmodule

// File: rtl/i2c_ctl_bank.sv
module i2c_ctl_bank
    import i2c_ctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h40,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [VOL_W-1:0]  vol_left,
    output logic [VOL_W-1:0]  vol_right,
    output logic [VOL_W-1:0]  vol_ctr,
    output logic [TONE_W-1:0] treble,
    output logic [TONE_W-1:0] bass,
    output logic [TONE_W-1:0] surround_lvl,
    output logic              agc_en,
    output logic              mute,
    output logic              ctr_mute,
    output logic              surround_en,
    output logic              bass_mix_en,
    output logic              ctr_src_ext,
    output logic              loop_en,
    output logic              ext_dac
);

    logic        scl_sync, scl_rise, scl_fall;
    logic        sda_sync, sda_rise, sda_fall;
    logic        start_det, stop_det, ignoring;
    logic        byte_stb, byte_is_sub, wr_en;
    byte_t       byte_data;
    bank_t       bank;
    ctl_fields_t fields;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst(rst), .line_in(scl_in),
        .line_s(scl_sync), .line_rise(scl_rise), .line_fall(scl_fall)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst(rst), .line_in(sda_in),
        .line_s(sda_sync), .line_rise(sda_rise), .line_fall(sda_fall)
    );

    i2c_rx_fsm #(.DEV_ADDR(DEV_ADDR)) u_rx (
        .clk(clk), .rst(rst),
        .scl_s(scl_sync), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_sync), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .start_det(start_det), .stop_det(stop_det),
        .sda_oe(sda_oe), .ignoring(ignoring),
        .byte_stb(byte_stb), .byte_is_sub(byte_is_sub), .byte_data(byte_data)
    );

    ctl_regfile u_regs (
        .clk(clk), .rst(rst),
        .byte_stb(byte_stb), .byte_is_sub(byte_is_sub), .byte_data(byte_data),
        .wr_en(wr_en), .bank(bank)
    );

    assign fields       = decode_bank(bank);
    assign vol_left     = fields.vol_left;
    assign vol_right    = fields.vol_right;
    assign vol_ctr      = fields.vol_ctr;
    assign treble       = fields.treble;
    assign bass         = fields.bass;
    assign surround_lvl = fields.surround_lvl;
    assign agc_en       = fields.agc_en;
    assign mute         = fields.mute;
    assign ctr_mute     = fields.ctr_mute;
    assign surround_en  = fields.surround_en;
    assign bass_mix_en  = fields.bass_mix_en;
    assign ctr_src_ext  = fields.ctr_src_ext;
    assign loop_en      = fields.loop_en;
    assign ext_dac      = fields.ext_dac;

endmodule

// File: rtl/i2c_ctl_bank_chk.sv
module i2c_ctl_bank_chk
    import i2c_ctl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             scl_sync,
    input logic             sda_oe,
    input logic             stop_det,
    input logic             ignoring,
    input logic             wr_en,
    input bank_t            bank,
    input logic             mute,
    input logic             ctr_mute,
    input logic [VOL_W-1:0] vol_left,
    input logic [VOL_W-1:0] vol_right,
    input logic [VOL_W-1:0] vol_ctr
);

    // R11
    ack_on_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_sync);

    // R11
    ack_off_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe) |-> !scl_sync);

    // R1
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);

    // R2
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ignoring |-> (!sda_oe && !wr_en));

    // R6
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(bank));

    // R10
    reset_default_chk: assert property (@(posedge clk)
        rst |=> (mute && ctr_mute && vol_left == '0 && vol_right == '0 && vol_ctr == '0));

endmodule

bind i2c_ctl_bank i2c_ctl_bank_chk u_chk (
    .clk(clk), .rst(rst), .scl_sync(scl_sync), .sda_oe(sda_oe),
    .stop_det(stop_det), .ignoring(ignoring), .wr_en(wr_en), .bank(bank),
    .mute(mute), .ctr_mute(ctr_mute),
    .vol_left(vol_left), .vol_right(vol_right), .vol_ctr(vol_ctr)
);

// File: tb/tb_i2c_ctl_bank.sv
module tb_i2c_ctl_bank;

    localparam int Q = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_bus;
    logic sda_oe;
    logic [5:0] vol_left, vol_right, vol_ctr;
    logic [3:0] treble, bass, surround_lvl;
    logic agc_en, mute, ctr_mute, surround_en, bass_mix_en, ctr_src_ext, loop_en, ext_dac;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [7:0] m [6];

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_ctl_bank dut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
        .vol_left(vol_left), .vol_right(vol_right), .vol_ctr(vol_ctr),
        .treble(treble), .bass(bass), .surround_lvl(surround_lvl),
        .agc_en(agc_en), .mute(mute), .ctr_mute(ctr_mute), .surround_en(surround_en),
        .bass_mix_en(bass_mix_en), .ctr_src_ext(ctr_src_ext), .loop_en(loop_en),
        .ext_dac(ext_dac)
    );

    // {sub-address, byte count, d0, d1, d2}
    localparam logic [39:0] VEC [0:7] = '{
        {8'h00, 8'd3, 8'hBF, 8'h25, 8'h7F},  // R4 R7 R9 auto-increment from 0
        {8'h03, 8'd3, 8'h8A, 8'h85, 8'hC3},  // R8 R9 upper registers
        {8'h84, 8'd3, 8'h01, 8'h02, 8'h8F},  // R5 renewal on register 4
        {8'h04, 8'd3, 8'h03, 8'h44, 8'h7C},  // R4 pointer stays at 5
        {8'h81, 8'd2, 8'h80, 8'h3F, 8'h00},  // R5 renewal on register 1
        {8'h00, 8'd1, 8'h00, 8'h00, 8'h00},  // R7 volume back to minimum
        {8'h02, 8'd2, 8'hC0, 8'h0F, 8'h00},  // R9 center mute with surround
        {8'h0A, 8'd2, 8'h55, 8'h66, 8'h00}   // R6 unmapped low nibble
    };

    task automatic wq();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 6; i++) m[i] = 8'h00;
        m[1] = 8'h80;
        m[2] = 8'h80;
    endtask

    task automatic model_write(input logic [7:0] sub, input int n, input logic [23:0] ds);
        int  p;
        bit  ok;
        p  = int'(sub[3:0]);
        ok = (sub[6:4] == 3'b000) && (p < 6);
        for (int k = 0; k < n; k++) begin
            if (ok) m[p] = ds[23-8*k -: 8];
            if (!sub[7] && ok && p < 5) p++;
        end
    endtask

    task automatic check_fields(input string ctx);
        logic [31:0] ev, av, et, at, es, as_;
        ev  = {14'h0, m[0][5:0], m[1][5:0], m[2][5:0]};
        av  = {14'h0, vol_left, vol_right, vol_ctr};
        et  = {20'h0, m[3][3:0], m[5][3:0], m[4][3:0]};
        at  = {20'h0, treble, bass, surround_lvl};
        es  = {24'h0, m[0][7], m[1][7], m[2][7], m[2][6], m[3][7], m[4][7], m[5][7], m[5][6]};
        as_ = {24'h0, agc_en, mute, ctr_mute, surround_en, bass_mix_en, ctr_src_ext, loop_en, ext_dac};
        chk(av == ev, {"R7 volumes ", ctx}, av, ev);
        chk(at == et, {"R8 tone/surround ", ctx}, at, et);
        chk(as_ == es, {"R9 switches ", ctx}, as_, es);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked, output bit released);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq();
            scl_m = 1'b1; wq(); wq();
            scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        acked = (sda_bus == 1'b0);
        wq();
        scl_m = 1'b0; wq();
        released = (sda_oe == 1'b0);
    endtask

    task automatic write_frame(input logic [7:0] sub, input int n, input logic [23:0] ds, input string ctx);
        bit a, r;
        i2c_start();
        send_byte(8'h80, a, r);
        chk(a, {"R2 address ack ", ctx}, 32'(a), 1);
        chk(r, {"R11 release after ack ", ctx}, 32'(r), 1);
        send_byte(sub, a, r);
        chk(a, {"R3 sub-address ack ", ctx}, 32'(a), 1);
        for (int k = 0; k < n; k++) begin
            send_byte(ds[23-8*k -: 8], a, r);
            chk(a, {"R3 data ack ", ctx}, 32'(a), 1);
        end
        i2c_stop();
        model_write(sub, n, ds);
        check_fields(ctx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        bit a, r;
        model_reset();
        repeat (5) @(posedge clk);
        #1;
        rst = 1'b0;
        wq();

        // R10: defaults after reset
        check_fields("R10 reset");
        chk(sda_oe == 1'b0, "R10 sda released", 32'(sda_oe), 0);

        // Table walk: R4 R5 R6 R7 R8 R9
        for (int v = 0; v < 8; v++) begin
            write_frame(VEC[v][39:32], int'(VEC[v][31:24]), VEC[v][23:0], $sformatf("vec%0d", v));
        end

        // R6: upper nibble 9 is unmapped
        write_frame(8'h90, 2, 24'h3F3F00, "R6 nibble9");

        // R2: foreign address, then the read address
        i2c_start();
        send_byte(8'h82, a, r);
        chk(!a, "R2 foreign address nack", 32'(a), 0);
        send_byte(8'h00, a, r);
        chk(!a, "R2 ignored sub nack", 32'(a), 0);
        send_byte(8'h3F, a, r);
        chk(!a, "R2 ignored data nack", 32'(a), 0);
        i2c_stop();
        check_fields("R2 foreign");

        i2c_start();
        send_byte(8'h81, a, r);
        chk(!a, "R2 read address nack", 32'(a), 0);
        send_byte(8'h01, a, r);
        send_byte(8'h3F, a, r);
        chk(!a, "R2 read frame data nack", 32'(a), 0);
        i2c_stop();
        check_fields("R2 read");

        // R1: bytes after a stop, without a start
        scl_m = 1'b0; wq();
        send_byte(8'h80, a, r);
        chk(!a, "R1 no start address nack", 32'(a), 0);
        send_byte(8'h00, a, r);
        send_byte(8'h15, a, r);
        chk(!a, "R1 no start data nack", 32'(a), 0);
        scl_m = 1'b1; wq();
        check_fields("R1 stray");

        // R12: repeated start between two bursts
        i2c_start();
        send_byte(8'h80, a, r);
        send_byte(8'h00, a, r);
        send_byte(8'h11, a, r);
        chk(a, "R12 first burst ack", 32'(a), 1);
        i2c_start();
        send_byte(8'h80, a, r);
        chk(a, "R12 readdress ack", 32'(a), 1);
        send_byte(8'h02, a, r);
        send_byte(8'h33, a, r);
        chk(a, "R12 second burst ack", 32'(a), 1);
        i2c_stop();
        model_write(8'h00, 1, 24'h110000);
        model_write(8'h02, 1, 24'h330000);
        check_fields("R12 repeated start");

        // R10: reset again after writes
        @(posedge clk); #1;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        wq();
        model_reset();
        check_fields("R10 second reset");

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule